// File: doc/BRIEF.md
# DRAM Command Sub-sequence Sequencer

This block issues a programmed batch of DRAM commands during memory training. Software fills up to four slot registers. Each slot names a command repetition count, a gap between successive commands, an idle period after its last command, and a data-direction tag. A sequence-control register sets how many times the whole chain of slots runs and how many wait cycles separate passes. Writing a non-zero pass count starts the run.

On every issued command the block raises a one-cycle strobe together with the active slot index and that slot's direction tag. The run stops in one of four ways: it finishes normally, software aborts it, an error input halts it when stop-on-error is set, or an external panic-refresh request aborts it. Status outputs report idle, normal completion, error halt and panic abort. A separate trigger output marks the first error seen in a run.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, `seq_idle` is 1 and `cmd_vld`, `seq_done`, `err_halted`, `panic_abort` and `err_trig` are all 0.
- R2: A write to address 4 (the sequence register) carries these fields: wdata[7:0] pass count, [16:8] wait cycles after each pass, [18:17] index of the last slot to run, [19] stop-on-error, [20] trigger enable. If the block is idle and the pass count is non-zero, the first command strobe appears in the second cycle after the clock edge that captures the write. A pass count of zero does not start a run.
- R3: A write to address s (0..3) programs slot s with these fields: wdata[8:0] repetitions, [13:9] gap, [22:14] post-slot idle, [24:23] direction (00 none, 01 read, 10 write, 11 both). Within each pass, slots 0 through the last-slot index run in ascending order. Every strobe presents that slot's index on `cmd_slot` and its direction on `cmd_dir`.
- R4: A slot with repetition count N issues N commands, and a count of 0 issues one. Each command is a single strobe cycle. A gap of G puts exactly G strobe-free cycles between successive commands of the slot, and G = 0 issues them back to back.
- R5: A slot with post-slot idle I leaves exactly I strobe-free cycles after its last command, before the next slot, the inter-pass wait or completion.
- R6: With pass count P (1..254) and wait W, the slot chain runs P times, with W strobe-free cycles between passes. In the cycle after the last pass's final idle cycle, `seq_idle` and `seq_done` are both 1.
- R7: A pass count of 255 repeats forever without decrementing. Writing the sequence register with a pass count of 0 while busy aborts the run: `seq_idle` is 1 two cycles after the capturing edge, `seq_done` stays 0, and no further strobes follow.
- R8: With stop-on-error set, an `err_in` pulse while busy halts the run in the next cycle, sets `err_halted`, clears the pass count and issues no further strobes.
- R9: With trigger enable set, the first `err_in` while busy drives `err_trig` high, and it stays high until the next run starts. Without stop-on-error the run continues to completion.
- R10: A `panic_in` pulse while busy aborts the run in the next cycle, sets `panic_abort`, clears the pass count and issues no further strobes.
- R11: While busy, slot writes are ignored, and sequence writes with a non-zero pass count are ignored. A sequence write with a zero pass count only clears the pass count. While idle, all writes take effect.
- R12: Starting a new run clears `seq_done`, `err_halted`, `panic_abort` and `err_trig`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0..3 slots, 4 sequence |
| cfg_wdata | input | 32 | Configuration write data |
| err_in | input | 1 | Error indication from data compare |
| panic_in | input | 1 | Panic-refresh abort request |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_slot | output | 2 | Slot index of the issued command |
| cmd_dir | output | 2 | Data-direction tag of the issued command |
| seq_idle | output | 1 | No run in progress |
| seq_done | output | 1 | Last run completed normally |
| err_halted | output | 1 | Last run halted by stop-on-error |
| panic_abort | output | 1 | Last run aborted by panic request |
| err_trig | output | 1 | First-error trigger |

## Verification
Some behaviours are checked by assertions on every cycle. These are the start edge, the immediate halt on error, panic and abort, the trigger's persistence, gap spacing after a non-final command, the decrement of the pass count, and the freezing of slot and sequence fields under writes made while busy. Other behaviours depend on whole runs, and only the bench scenarios can show them. These are the exact strobe-by-strobe pattern of slot order, repetition counts, gaps, idles and inter-pass waits, the completion cycle, the endless mode at 255, and the effect of ignored writes on later strobes. The bench sweeps repetitions, gaps, idles, slot counts, passes and waits, and compares each strobe cycle to a schedule it computes arithmetically.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int REP_W     = 9;
    localparam int GAP_W     = 5;
    localparam int IDLE_W    = 9;
    localparam int DIR_W     = 2;
    localparam int ITER_W    = 8;
    localparam int WAIT_W    = 9;
    localparam int CNT_W     = (IDLE_W > WAIT_W) ? IDLE_W : WAIT_W;

    localparam logic [ITER_W-1:0] ITER_FOREVER = '1;
    localparam logic [ADDR_W-1:0] SEQ_ADDR     = ADDR_W'(NUM_SLOTS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_SLOT_IDLE,
        ST_ITER_WAIT
    } seq_state_e;

    // packed LSB-first: reps at bit 0, gap, idle, dir on top
    typedef struct packed {
        logic [DIR_W-1:0]  dir;
        logic [IDLE_W-1:0] idle;
        logic [GAP_W-1:0]  gap;
        logic [REP_W-1:0]  reps;
    } slot_cfg_t;

    typedef struct packed {
        logic              trig_en;
        logic              stop_en;
        logic [SLOT_W-1:0] last_slot;
        logic [WAIT_W-1:0] wait_len;
    } seq_cfg_t;

    localparam int SLOT_CFG_W = $bits(slot_cfg_t);
    localparam int SEQ_CFG_W  = $bits(seq_cfg_t);

endpackage

// File: rtl/cmdseq_regs.sv
module cmdseq_regs
    import cmdseq_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    input  logic                               busy_i,
    input  logic                               iter_dec_i,
    input  logic                               iter_clr_i,
    output slot_cfg_t [NUM_SLOTS-1:0]          slots_o,
    output seq_cfg_t                           seq_o,
    output logic [ITER_W-1:0]                  iter_o
);

    typedef struct packed {
        slot_cfg_t [NUM_SLOTS-1:0] slots;
        seq_cfg_t                  seq;
        logic [ITER_W-1:0]         iter;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 seq_hit;
    logic [ITER_W-1:0]    wr_iter;
    logic                 unused_bits;

    assign seq_hit     = we_i && (addr_i == SEQ_ADDR);
    assign wr_iter     = wdata_i[ITER_W-1:0];
    assign unused_bits = ^wdata_i[DATA_W-1:SLOT_CFG_W];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_hit
        assign slot_hit[i] = we_i && !busy_i && (addr_i == ADDR_W'(i));

        assert_slot_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_i && we_i && addr_i == ADDR_W'(i)) |=> $stable(regs_q.slots[i]));
    end

    always_comb begin
        regs_d = regs_q;
        if (iter_clr_i) begin
            regs_d.iter = '0;
        end else if (iter_dec_i && regs_q.iter != ITER_FOREVER && regs_q.iter != '0) begin
            regs_d.iter = regs_q.iter - ITER_W'(1);
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_hit[i]) begin
                regs_d.slots[i] = wdata_i[SLOT_CFG_W-1:0];
            end
        end
        if (seq_hit) begin
            if (!busy_i) begin
                regs_d.seq  = wdata_i[ITER_W +: SEQ_CFG_W];
                regs_d.iter = wr_iter;
            end else if (wr_iter == '0) begin
                regs_d.iter = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign slots_o = regs_q.slots;
    assign seq_o   = regs_q.seq;
    assign iter_o  = regs_q.iter;

    assert_seq_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && seq_hit && wr_iter != '0) |=> $stable(regs_q.seq));

    assert_iter_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && seq_hit && wr_iter != '0 && !iter_dec_i && !iter_clr_i) |=> $stable(regs_q.iter));

    assert_iter_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_dec_i && !iter_clr_i && !we_i && regs_q.iter != ITER_FOREVER && regs_q.iter != '0)
        |=> regs_q.iter == $past(regs_q.iter) - ITER_W'(1));

    assert_forever_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.iter == ITER_FOREVER && !iter_clr_i && !we_i) |=> regs_q.iter == ITER_FOREVER);

endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
    import cmdseq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  slot_cfg_t [NUM_SLOTS-1:0] slots_i,
    input  seq_cfg_t                  seq_i,
    input  logic [ITER_W-1:0]         iter_i,
    input  logic                      err_i,
    input  logic                      panic_i,
    output logic                      busy_o,
    output logic                      iter_dec_o,
    output logic                      iter_clr_o,
    output logic                      cmd_vld_o,
    output logic [SLOT_W-1:0]         cmd_slot_o,
    output logic [DIR_W-1:0]          cmd_dir_o,
    output logic                      idle_o,
    output logic                      done_o,
    output logic                      err_halt_o,
    output logic                      panic_o,
    output logic                      trig_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic [REP_W-1:0]  rep;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              halted;
        logic              panicked;
        logic              trig;
    } eng_t;

    eng_t eng_d, eng_q;

    slot_cfg_t      cur;
    logic [REP_W:0] rep_nx;
    logic           rep_last;
    logic           slot_last;
    logic           slot_done;
    logic           busy;
    logic           dec;
    logic           clr;

    assign cur       = slots_i[eng_q.slot];
    assign rep_nx    = {1'b0, eng_q.rep} + (REP_W+1)'(1);
    assign rep_last  = rep_nx >= {1'b0, cur.reps};
    assign slot_last = eng_q.slot == seq_i.last_slot;
    assign busy      = eng_q.state != ST_IDLE;

    always_comb begin
        eng_d     = eng_q;
        slot_done = 1'b0;
        dec       = 1'b0;
        clr       = 1'b0;

        unique case (eng_q.state)
            ST_IDLE: begin
                if (iter_i != '0) begin
                    eng_d.state    = ST_ISSUE;
                    eng_d.slot     = '0;
                    eng_d.rep      = '0;
                    eng_d.done     = 1'b0;
                    eng_d.halted   = 1'b0;
                    eng_d.panicked = 1'b0;
                    eng_d.trig     = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (!rep_last) begin
                    eng_d.rep = rep_nx[REP_W-1:0];
                    if (cur.gap != '0) begin
                        eng_d.state = ST_GAP;
                        eng_d.cnt   = CNT_W'(cur.gap) - CNT_W'(1);
                    end
                end else if (cur.idle != '0) begin
                    eng_d.state = ST_SLOT_IDLE;
                    eng_d.cnt   = CNT_W'(cur.idle) - CNT_W'(1);
                end else begin
                    slot_done = 1'b1;
                end
            end
            ST_GAP: begin
                if (eng_q.cnt == '0) begin
                    eng_d.state = ST_ISSUE;
                end else begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end
            end
            ST_SLOT_IDLE: begin
                if (eng_q.cnt == '0) begin
                    slot_done = 1'b1;
                end else begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end
            end
            ST_ITER_WAIT: begin
                if (eng_q.cnt == '0) begin
                    eng_d.state = ST_ISSUE;
                    eng_d.slot  = '0;
                    eng_d.rep   = '0;
                end else begin
                    eng_d.cnt = eng_q.cnt - CNT_W'(1);
                end
            end
            default: eng_d.state = ST_IDLE;
        endcase

        // end of a slot: advance slot, close the pass, or finish
        if (slot_done) begin
            eng_d.rep = '0;
            if (!slot_last) begin
                eng_d.state = ST_ISSUE;
                eng_d.slot  = eng_q.slot + SLOT_W'(1);
            end else begin
                dec = iter_i != ITER_FOREVER;
                if (iter_i == ITER_W'(1)) begin
                    eng_d.state = ST_IDLE;
                    eng_d.done  = 1'b1;
                end else if (seq_i.wait_len != '0) begin
                    eng_d.state = ST_ITER_WAIT;
                    eng_d.cnt   = CNT_W'(seq_i.wait_len) - CNT_W'(1);
                end else begin
                    eng_d.state = ST_ISSUE;
                    eng_d.slot  = '0;
                end
            end
        end

        // abnormal endings take precedence over normal progress
        if (busy && err_i) begin
            if (seq_i.trig_en) begin
                eng_d.trig = 1'b1;
            end
            if (seq_i.stop_en) begin
                eng_d.state  = ST_IDLE;
                eng_d.halted = 1'b1;
                eng_d.done   = 1'b0;
                clr          = 1'b1;
            end
        end
        if (busy && panic_i) begin
            eng_d.state    = ST_IDLE;
            eng_d.panicked = 1'b1;
            eng_d.done     = 1'b0;
            clr            = 1'b1;
        end
        if (busy && iter_i == '0) begin
            eng_d.state = ST_IDLE;
            eng_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o     = busy;
    assign iter_dec_o = dec;
    assign iter_clr_o = clr;
    assign cmd_vld_o  = eng_q.state == ST_ISSUE;
    assign cmd_slot_o = eng_q.slot;
    assign cmd_dir_o  = cur.dir;
    assign idle_o     = !busy;
    assign done_o     = eng_q.done;
    assign err_halt_o = eng_q.halted;
    assign panic_o    = eng_q.panicked;
    assign trig_o     = eng_q.trig;

    assert_start_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && iter_i != '0) |=> cmd_vld_o);

    assert_gap_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && !rep_last && cur.gap != '0) |=> !cmd_vld_o);

    assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && iter_i == '0) |=> (idle_o && !done_o));

    assert_err_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && err_i && seq_i.stop_en) |=> (idle_o && err_halt_o && !cmd_vld_o));

    assert_trig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !(idle_o && iter_i != '0)) |=> trig_o);

    assert_panic_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && panic_i) |=> (idle_o && panic_o && !cmd_vld_o));

    assert_flags_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && iter_i != '0) |=> (!done_o && !err_halt_o && !panic_o));

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              err_in,
    input  logic              panic_in,
    output logic              cmd_vld,
    output logic [SLOT_W-1:0] cmd_slot,
    output logic [DIR_W-1:0]  cmd_dir,
    output logic              seq_idle,
    output logic              seq_done,
    output logic              err_halted,
    output logic              panic_abort,
    output logic              err_trig
);

    slot_cfg_t [NUM_SLOTS-1:0] slots;
    seq_cfg_t                  seq;
    logic [ITER_W-1:0]         iter;
    logic                      busy;
    logic                      iter_dec;
    logic                      iter_clr;

    cmdseq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .addr_i     (cfg_addr),
        .wdata_i    (cfg_wdata),
        .busy_i     (busy),
        .iter_dec_i (iter_dec),
        .iter_clr_i (iter_clr),
        .slots_o    (slots),
        .seq_o      (seq),
        .iter_o     (iter)
    );

    cmdseq_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .slots_i    (slots),
        .seq_i      (seq),
        .iter_i     (iter),
        .err_i      (err_in),
        .panic_i    (panic_in),
        .busy_o     (busy),
        .iter_dec_o (iter_dec),
        .iter_clr_o (iter_clr),
        .cmd_vld_o  (cmd_vld),
        .cmd_slot_o (cmd_slot),
        .cmd_dir_o  (cmd_dir),
        .idle_o     (seq_idle),
        .done_o     (seq_done),
        .err_halt_o (err_halted),
        .panic_o    (panic_abort),
        .trig_o     (err_trig)
    );

endmodule

// File: tb/tb_cmdseq_top.sv
module tb_cmdseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        err_in = 1'b0;
    logic        panic_in = 1'b0;
    logic        cmd_vld;
    logic [1:0]  cmd_slot;
    logic [1:0]  cmd_dir;
    logic        seq_idle, seq_done, err_halted, panic_abort, err_trig;

    int n_checks = 0;
    int n_fail   = 0;

    cmdseq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .err_in(err_in), .panic_in(panic_in),
        .cmd_vld(cmd_vld), .cmd_slot(cmd_slot), .cmd_dir(cmd_dir),
        .seq_idle(seq_idle), .seq_done(seq_done), .err_halted(err_halted),
        .panic_abort(panic_abort), .err_trig(err_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slot_word(int reps, int gap, int idle, int dir);
        return 32'(reps) | (32'(gap) << 9) | (32'(idle) << 14) | (32'(dir) << 23);
    endfunction

    function automatic logic [31:0] seq_word(int iter, int wt, int last, int stop, int trig);
        return 32'(iter) | (32'(wt) << 8) | (32'(last) << 17) | (32'(stop) << 19) | (32'(trig) << 20);
    endfunction

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic cfg_write(input int addr, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic run_case(input int reps, input int gap, input int idle,
                            input int last, input int iters, input int wt);
        int mism = 0;
        for (int s = 0; s <= last; s++)
            cfg_write(s, slot_word((reps + s) % 4, gap, idle, (s + reps) % 4));
        cfg_write(4, seq_word(iters, wt, last, 0, 0));
        for (int it = 0; it < iters; it++) begin
            for (int s = 0; s <= last; s++) begin
                int r_s = (reps + s) % 4;
                int eff = (r_s == 0) ? 1 : r_s;
                for (int r = 0; r < eff; r++) begin
                    @(negedge clk);
                    if (!cmd_vld || cmd_slot != 2'(s) || cmd_dir != 2'((s + reps) % 4)) mism++;
                    if (r < eff - 1)
                        for (int g = 0; g < gap; g++) begin
                            @(negedge clk);
                            if (cmd_vld) mism++;
                        end
                end
                for (int k = 0; k < idle; k++) begin
                    @(negedge clk);
                    if (cmd_vld) mism++;
                end
            end
            if (it < iters - 1)
                for (int k = 0; k < wt; k++) begin
                    @(negedge clk);
                    if (cmd_vld) mism++;
                end
        end
        chk(mism == 0, "R3 R4 R5 strobe schedule mismatches", mism, 0);
        @(negedge clk);
        chk(seq_idle && seq_done, "R6 idle and done after last pass", {seq_idle, seq_done}, 3);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int dir_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(seq_idle && !cmd_vld && !seq_done && !err_halted && !panic_abort && !err_trig,
            "R1 reset outputs", {seq_idle, cmd_vld, seq_done, err_halted, panic_abort, err_trig}, 32);

        // R2 zero pass count does not start
        cfg_write(0, slot_word(1, 0, 0, 1));
        cfg_write(4, seq_word(0, 0, 0, 0, 0));
        cnt = 0;
        repeat (4) begin @(negedge clk); if (cmd_vld || !seq_idle) cnt++; end
        chk(cnt == 0, "R2 zero pass count stays idle", cnt, 0);

        // R2 start timing
        cfg_write(4, seq_word(1, 0, 0, 0, 0));
        chk(!cmd_vld && seq_idle, "R2 no strobe in first cycle", cmd_vld, 0);
        @(negedge clk);
        chk(cmd_vld == 1'b1 && cmd_dir == 2'd1, "R2 strobe in second cycle", cmd_vld, 1);
        @(negedge clk);
        chk(seq_done == 1'b1, "R6 single command run done", seq_done, 1);

        // near-exhaustive sweep
        for (int reps = 0; reps < 4; reps++)
            for (int gap = 0; gap < 3; gap++)
                for (int idle = 0; idle < 3; idle++)
                    for (int li = 0; li < 2; li++)
                        for (int iters = 1; iters <= 2; iters++)
                            for (int wt = 0; wt < 3; wt++)
                                run_case(reps, gap, idle, li * 3, iters, wt);

        // R7 and R11: endless run, ignored writes, abort
        cfg_write(0, slot_word(2, 1, 0, 1));
        cfg_write(4, seq_word(255, 0, 0, 0, 0));
        cnt = 0;
        repeat (9) begin @(negedge clk); if (cmd_vld) cnt++; end
        chk(cnt == 6, "R4 two commands per three cycles", cnt, 6);
        cfg_write(0, slot_word(1, 0, 0, 2));
        cfg_write(4, seq_word(1, 0, 0, 0, 0));
        cnt = 0;
        dir_bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (cmd_vld) begin cnt++; if (cmd_dir != 2'd1) dir_bad++; end
        end
        chk(cnt == 20, "R7 endless run keeps issuing", cnt, 20);
        chk(dir_bad == 0, "R11 slot write ignored while busy", dir_bad, 0);
        cfg_write(4, seq_word(0, 0, 0, 0, 0));
        @(negedge clk);
        chk(seq_idle && !seq_done, "R7 abort idle without done", {seq_idle, seq_done}, 2);
        cnt = 0;
        repeat (10) begin @(negedge clk); if (cmd_vld) cnt++; end
        chk(cnt == 0, "R7 no strobes after abort", cnt, 0);

        // R11 writes take effect while idle
        cfg_write(0, slot_word(1, 0, 0, 3));
        cfg_write(4, seq_word(1, 0, 0, 0, 0));
        @(negedge clk);
        chk(cmd_vld && cmd_dir == 2'd3, "R11 idle slot write applied", cmd_dir, 3);

        // R8 and R9: stop on error with trigger
        @(negedge clk);
        cfg_write(0, slot_word(5, 3, 0, 2));
        cfg_write(4, seq_word(1, 0, 0, 1, 1));
        repeat (3) @(negedge clk);
        err_in = 1'b1;
        @(negedge clk);
        err_in = 1'b0;
        chk(seq_idle && err_halted, "R8 halted on error", {seq_idle, err_halted}, 3);
        chk(err_trig == 1'b1, "R9 trigger on first error", err_trig, 1);
        cnt = 0;
        repeat (10) begin @(negedge clk); if (cmd_vld || seq_done) cnt++; end
        chk(cnt == 0, "R8 no strobes and no done after halt", cnt, 0);

        // R9 and R12: trigger without stop, run completes
        cfg_write(4, seq_word(1, 0, 0, 0, 1));
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k == 0)
                chk(!err_halted && !err_trig && !seq_done, "R12 flags cleared on start",
                    {err_halted, err_trig, seq_done}, 0);
            if (k == 4) err_in = 1'b1;
            if (k == 5) err_in = 1'b0;
            if (cmd_vld) cnt++;
            if (seq_idle) break;
        end
        chk(cnt == 5, "R9 run continues without stop", cnt, 5);
        chk(err_trig && seq_done && !err_halted, "R9 trigger held to completion",
            {err_trig, seq_done, err_halted}, 6);

        // R10 panic abort
        cfg_write(0, slot_word(2, 1, 0, 1));
        cfg_write(4, seq_word(255, 0, 0, 0, 0));
        repeat (4) @(negedge clk);
        panic_in = 1'b1;
        @(negedge clk);
        panic_in = 1'b0;
        chk(seq_idle && panic_abort && !seq_done, "R10 panic abort flags",
            {seq_idle, panic_abort, seq_done}, 6);
        cnt = 0;
        repeat (8) begin @(negedge clk); if (cmd_vld) cnt++; end
        chk(cnt == 0, "R10 no restart after panic", cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule